// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave for an Audio Processor

This block is a receive-only I2C target that runs from a fast system clock. It filters and oversamples the SCL and SDA lines, recognises start and stop conditions, and compares the first byte of each transfer against a 7-bit device address set by a parameter. When the address matches and the transfer is a write, the next byte selects a register and every byte after that is written into the control register map. The stored register index moves up by one after each data byte, so a single transfer can load several registers in turn.

The register map is sparse. It has two 6-bit volume fields, two 4-bit tone fields (bass and treble) and a 6-bit switch register that holds the mute, effect, stereo, mode and source controls. All fields are presented as parallel outputs to the analog section. Reset puts the output in the muted state, and it stays muted until software writes a switch word with the mute bit cleared. Toward the bus the block only drives an open-drain pull request, used for the acknowledge bit.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset the volume, bass and treble fields are all zero, every switch bit except mute is zero, mute is 1, and the SDA pull request is released.
- R2: An SDA fall while SCL is high is a start. It restarts address reception from any state, including in the middle of a byte. An SDA rise while SCL is high is a stop, after which the block stays idle and pulls nothing until the next start.
- R3: The first byte after a start carries the address in bits 7..1, MSB first, and the direction in bit 0 (0 = write). A match with DEV_ADDR and direction 0 is acknowledged. A mismatch or a read is not acknowledged, and the rest of that transfer is ignored.
- R4: The byte after the address is the register index. Index 0 loads left volume, 1 right volume, 2 bass and 3 treble. Volume takes data bits 5..0, tone takes data bits 3..0, and the upper data bits are discarded.
- R5: Index 8 loads the switch register from data bits 5..0. The bit mapping is: bit5 mute, bit4 effect, bit3 stereo select, bits 2..1 mode (bit2 high), bit0 source select.
- R6: After each data byte the register index increases by one. A data byte whose index is not 0..3 or 8 is acknowledged, changes no output, and the index still advances.
- R7: A register changes only when all eight bits of its data byte have been received. A byte cut short by a start or a stop changes nothing.
- R8: The block pulls SDA low through the ninth clock after an accepted address, after the index byte and after every data byte. The pull is set and released only while SCL is low.
- R9: A single-clock pulse on SCL while SCL is low, or on SDA while SCL is high, is filtered out. It does not count as a clock edge, a start or a stop.
- R10: Transfers work at 100 kHz SCL timing and at faster timings whose SCL high and low phases each last at least 16 system clocks.
- R11: Mute stays 1 until a switch write with bit5 = 0. A later switch write with bit5 = 1, or a reset, mutes the output again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| vol_left_o | output | VOL_W | Left volume code |
| vol_right_o | output | VOL_W | Right volume code |
| bass_o | output | TONE_W | Bass code |
| treble_o | output | TONE_W | Treble code |
| mute_o | output | 1 | 1 = outputs muted |
| effect_o | output | 1 | Effect select bit |
| stereo_o | output | 1 | Stereo/linear select bit |
| mode_o | output | 2 | Sound mode select |
| src_sel_o | output | 1 | Input source select |

## Verification
The end of each data byte writes a register and advances the register index in the same clock, and the index step is easy to get wrong. Bursts that cross from index 3 into the unused 4..7 range and from 7 into 8 make both actions happen on every byte. A result is judged by which output field received which byte of the burst. A second collision is a start or a stop that arrives while a byte is only partly shifted in: the bench cuts bytes off after a few bits and then checks that no field moved and that the next complete transfer lands normally.

// File: rtl/audio_i2c_pkg.sv
package audio_i2c_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_ADDR,
      RX_SUB,
      RX_DATA,
      RX_SKIP
   } rx_state_e;

   // Register indices: the switch register is decoded apart from the others
   localparam logic [7:0] IDX_VOL_L  = 8'h00;
   localparam logic [7:0] IDX_VOL_R  = 8'h01;
   localparam logic [7:0] IDX_BASS   = 8'h02;
   localparam logic [7:0] IDX_TREBLE = 8'h03;
   localparam logic [7:0] IDX_SWITCH = 8'h08;

   // Switch register layout
   localparam int SW_W      = 6;
   localparam int SW_MUTE   = 5;
   localparam int SW_EFFECT = 4;
   localparam int SW_STEREO = 3;
   localparam int SW_MODE_H = 2;
   localparam int SW_MODE_L = 1;
   localparam int SW_SRC    = 0;

   localparam logic [SW_W-1:0] SW_RESET = 6'b100000;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int HALF = FILT_LEN / 2;
   localparam int CW   = $clog2(FILT_LEN + 1);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   generate
      if (FILT_LEN == 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_majority
         logic [FILT_LEN-1:0] hist_q;
         logic [CW-1:0]       ones;

         always_comb begin
            ones = '0;
            for (int i = 0; i < FILT_LEN; i++)
               ones = ones + CW'(hist_q[i]);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               line_o <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
               line_o <= (ones > CW'(HALF));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/i2c_wr_receiver.sv
module i2c_wr_receiver
   import audio_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h41
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   output logic       sda_pull,
   output logic [7:0] rx_byte,
   output logic       sub_stb,
   output logic       data_stb
);

   rx_state_e  state_q;
   logic       scl_q, sda_q;
   logic [3:0] bit_cnt;
   logic       in_ack;
   logic       start_c, stop_c, scl_rise, scl_fall;
   logic       byte_full;
   logic       active;

   assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign byte_full = (bit_cnt == 4'd8);
   assign active    = (state_q == RX_ADDR) || (state_q == RX_SUB) ||
                      (state_q == RX_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         state_q  <= RX_IDLE;
         bit_cnt  <= '0;
         in_ack   <= 1'b0;
         sda_pull <= 1'b0;
         rx_byte  <= '0;
         sub_stb  <= 1'b0;
         data_stb <= 1'b0;
      end else begin
         scl_q    <= scl_f;
         sda_q    <= sda_f;
         sub_stb  <= 1'b0;
         data_stb <= 1'b0;
         if (start_c) begin
            state_q  <= RX_ADDR;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            state_q  <= RX_IDLE;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (active) begin
            if (in_ack) begin
               if (scl_fall) begin
                  in_ack   <= 1'b0;
                  sda_pull <= 1'b0;
                  bit_cnt  <= '0;
                  state_q  <= (state_q == RX_ADDR) ? RX_SUB : RX_DATA;
               end
            end else if (scl_rise && !byte_full) begin
               rx_byte <= {rx_byte[6:0], sda_f};
               bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && byte_full) begin
               unique case (state_q)
                  RX_ADDR: begin
                     if (rx_byte[7:1] == DEV_ADDR && !rx_byte[0]) begin
                        in_ack   <= 1'b1;
                        sda_pull <= 1'b1;
                     end else begin
                        state_q  <= RX_SKIP;
                     end
                  end
                  RX_SUB: begin
                     in_ack   <= 1'b1;
                     sda_pull <= 1'b1;
                     sub_stb  <= 1'b1;
                  end
                  default: begin
                     in_ack   <= 1'b1;
                     sda_pull <= 1'b1;
                     data_stb <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
   import audio_i2c_pkg::*;
#(
   parameter int VOL_W  = 6,
   parameter int TONE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        wr_byte,
   input  logic              sub_stb,
   input  logic              data_stb,
   output logic [7:0]        wr_ptr,
   output logic [VOL_W-1:0]  vol_l,
   output logic [VOL_W-1:0]  vol_r,
   output logic [TONE_W-1:0] bass,
   output logic [TONE_W-1:0] treble,
   output logic [SW_W-1:0]   sw
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         vol_l  <= '0;
         vol_r  <= '0;
         bass   <= '0;
         treble <= '0;
         sw     <= SW_RESET;
      end else if (sub_stb) begin
         wr_ptr <= wr_byte;
      end else if (data_stb) begin
         wr_ptr <= wr_ptr + 8'd1;
         unique case (wr_ptr)
            IDX_VOL_L:  vol_l  <= wr_byte[VOL_W-1:0];
            IDX_VOL_R:  vol_r  <= wr_byte[VOL_W-1:0];
            IDX_BASS:   bass   <= wr_byte[TONE_W-1:0];
            IDX_TREBLE: treble <= wr_byte[TONE_W-1:0];
            IDX_SWITCH: sw     <= wr_byte[SW_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave
   import audio_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h41,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3,
   parameter int         VOL_W       = 6,
   parameter int         TONE_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic [VOL_W-1:0]  vol_left_o,
   output logic [VOL_W-1:0]  vol_right_o,
   output logic [TONE_W-1:0] bass_o,
   output logic [TONE_W-1:0] treble_o,
   output logic              mute_o,
   output logic              effect_o,
   output logic              stereo_o,
   output logic [1:0]        mode_o,
   output logic              src_sel_o
);

   localparam int NLINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1 || (FILT_LEN % 2) == 0) begin : g_bad_filt
         $error("FILT_LEN must be odd and positive");
      end
      if (VOL_W < 1 || VOL_W > 8) begin : g_bad_vol
         $error("VOL_W must lie in 1..8");
      end
      if (TONE_W < 1 || TONE_W > 8) begin : g_bad_tone
         $error("TONE_W must lie in 1..8");
      end
   endgenerate

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] clean_lines;
   logic [7:0]        rx_byte;
   logic              sub_stb, data_stb;
   logic [7:0]        wr_ptr;
   logic [SW_W-1:0]   sw;

   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < NLINES; g++) begin : g_line
         i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(clean_lines[g])
         );
      end
   endgenerate

   i2c_wr_receiver #(
      .DEV_ADDR(DEV_ADDR)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (clean_lines[1]),
      .sda_f   (clean_lines[0]),
      .sda_pull(sda_pull_o),
      .rx_byte (rx_byte),
      .sub_stb (sub_stb),
      .data_stb(data_stb)
   );

   audio_ctl_regs #(
      .VOL_W (VOL_W),
      .TONE_W(TONE_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_byte (rx_byte),
      .sub_stb (sub_stb),
      .data_stb(data_stb),
      .wr_ptr  (wr_ptr),
      .vol_l   (vol_left_o),
      .vol_r   (vol_right_o),
      .bass    (bass_o),
      .treble  (treble_o),
      .sw      (sw)
   );

   assign mute_o    = sw[SW_MUTE];
   assign effect_o  = sw[SW_EFFECT];
   assign stereo_o  = sw[SW_STEREO];
   assign mode_o    = sw[SW_MODE_H:SW_MODE_L];
   assign src_sel_o = sw[SW_SRC];

endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk #(
   parameter int VOL_W  = 6,
   parameter int TONE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_pull_o,
   input logic              sub_stb,
   input logic              data_stb,
   input logic [7:0]        wr_ptr,
   input logic [VOL_W-1:0]  vol_left_o,
   input logic [VOL_W-1:0]  vol_right_o,
   input logic [TONE_W-1:0] bass_o,
   input logic [TONE_W-1:0] treble_o,
   input logic              mute_o,
   input logic              effect_o,
   input logic              stereo_o,
   input logic [1:0]        mode_o,
   input logic              src_sel_o
);

   logic [2*VOL_W+2*TONE_W+5:0] regs_all;
   assign regs_all = {vol_left_o, vol_right_o, bass_o, treble_o,
                      mute_o, effect_o, stereo_o, mode_o, src_sel_o};

   // R1: leaving reset, the output is muted
   a_r1_mute_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> mute_o);

   // R8: the acknowledge pull only moves while SCL is low
   a_r8_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_i);

   // R6: each data byte advances the register index by one
   a_r6_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb |=> (wr_ptr == $past(wr_ptr) + 8'd1));

   // R7: output fields change only after a complete data byte
   a_r7_regs_need_full_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_all) |-> $past(data_stb));

   // R11: mute is released only by a data write
   a_r11_unmute_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute_o) |-> $past(data_stb));

   // R4: index byte and data byte are never taken in the same cycle
   a_r4_one_byte_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sub_stb, data_stb}));

endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_chk #(
   .VOL_W (VOL_W),
   .TONE_W(TONE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_i      (scl_i),
   .sda_pull_o (sda_pull_o),
   .sub_stb    (sub_stb),
   .data_stb   (data_stb),
   .wr_ptr     (wr_ptr),
   .vol_left_o (vol_left_o),
   .vol_right_o(vol_right_o),
   .bass_o     (bass_o),
   .treble_o   (treble_o),
   .mute_o     (mute_o),
   .effect_o   (effect_o),
   .stereo_o   (stereo_o),
   .mode_o     (mode_o),
   .src_sel_o  (src_sel_o)
);

// File: tb/tb_audio_ctl_i2c_slave.sv
module tb_audio_ctl_i2c_slave;

   localparam logic [6:0] ADDR = 7'h41;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_pull;
   logic [5:0] vol_l, vol_r;
   logic [3:0] bass, treble;
   logic mute, effect, stereo, src;
   logic [1:0] mode;

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   audio_ctl_i2c_slave #(.DEV_ADDR(ADDR)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .vol_left_o(vol_l), .vol_right_o(vol_r),
      .bass_o(bass), .treble_o(treble), .mute_o(mute), .effect_o(effect),
      .stereo_o(stereo), .mode_o(mode), .src_sel_o(src)
   );

   int tests = 0;
   int fails = 0;
   int q = 20;
   int cyc = 0;
   logic glitch_en = 1'b0;
   logic [7:0] tx [0:15];
   logic ack_r [0:16];

   // model of the register map
   logic [5:0] m_vl, m_vr, m_sw;
   logic [3:0] m_ba, m_tr;

   // {index, data} pairs, each written in its own transfer
   localparam logic [15:0] VEC [0:11] = '{
      16'h003F, 16'h01C5, 16'h02FA, 16'h03F6, 16'h08DE, 16'h0500,
      16'h00C0, 16'h08E9, 16'h09FF, 16'h01FF, 16'h0301, 16'h0455
   };

   task automatic model_reset();
      m_vl = '0; m_vr = '0; m_ba = '0; m_tr = '0; m_sw = 6'b100000;
   endtask

   task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
      case (idx)
         8'h00: m_vl = d[5:0];
         8'h01: m_vr = d[5:0];
         8'h02: m_ba = d[3:0];
         8'h03: m_tr = d[3:0];
         8'h08: m_sw = d[5:0];
         default: ;
      endcase
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      chk(req, {6'd0, vol_l, vol_r, bass, treble, mute, effect, stereo, mode, src},
               {6'd0, m_vl, m_vr, m_ba, m_tr, m_sw});
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wait_cyc(q);
      scl_m = 1'b1; wait_cyc(q);
      sda_m = 1'b0; wait_cyc(q);
      scl_m = 1'b0; wait_cyc(q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wait_cyc(q);
      scl_m = 1'b1; wait_cyc(q);
      sda_m = 1'b1; wait_cyc(q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;
      wait_cyc(q);
      scl_m = 1'b1;
      wait_cyc(q);
      if (glitch_en && b) begin
         sda_m = 1'b0; wait_cyc(1); sda_m = 1'b1;
      end
      wait_cyc(q);
      scl_m = 1'b0;
      if (glitch_en) begin
         wait_cyc(q / 2); scl_m = 1'b1; wait_cyc(1); scl_m = 1'b0; wait_cyc(q / 2);
      end else begin
         wait_cyc(q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wait_cyc(q);
      scl_m = 1'b1; wait_cyc(q);
      ack = sda_pull;
      wait_cyc(q);
      scl_m = 1'b0; wait_cyc(q);
   endtask

   task automatic xfer(input logic [6:0] a, input logic rw, input int n);
      logic ak;
      i2c_start();
      send_byte({a, rw}, ak); ack_r[0] = ak;
      for (int i = 0; i < n; i++) begin
         send_byte(tx[i], ak); ack_r[i + 1] = ak;
      end
      i2c_stop();
      wait_cyc(10);
   endtask

   initial begin : main
      logic ak;
      model_reset();
      wait_cyc(5);
      chk("R1 reset pull", {31'd0, sda_pull}, 32'd0);
      chk_regs("R1 reset values");
      rst_n = 1'b1;
      wait_cyc(10);
      chk_regs("R1 after release");

      // table walk, R4 R5
      for (int v = 0; v < 12; v++) begin
         tx[0] = VEC[v][15:8]; tx[1] = VEC[v][7:0];
         xfer(ADDR, 1'b0, 2);
         model_write(VEC[v][15:8], VEC[v][7:0]);
         chk_regs($sformatf("R4 R5 vector %0d", v));
         chk("R8 acks on table", {29'd0, ack_r[0], ack_r[1], ack_r[2]}, 32'd7);
      end
      chk("R2 idle after stop", {31'd0, sda_pull}, 32'd0);

      // R6: burst 0..5 crosses into unmapped indices
      tx[0] = 8'h00; tx[1] = 8'h2A; tx[2] = 8'h15; tx[3] = 8'hF9;
      tx[4] = 8'hF4; tx[5] = 8'h3F; tx[6] = 8'h00;
      xfer(ADDR, 1'b0, 7);
      model_write(8'h00, 8'h2A); model_write(8'h01, 8'h15);
      model_write(8'h02, 8'hF9); model_write(8'h03, 8'hF4);
      chk_regs("R6 burst from 0");
      chk("R6 unmapped acked", {31'd0, ack_r[5] & ack_r[6]}, 32'd1);

      // R6: burst from 6 reaches switch at 8
      tx[0] = 8'h06; tx[1] = 8'h11; tx[2] = 8'h22; tx[3] = 8'hD5; tx[4] = 8'h3C;
      xfer(ADDR, 1'b0, 5);
      model_write(8'h08, 8'hD5);
      chk_regs("R6 R11 burst from 6 into switch");
      chk("R11 unmuted", {31'd0, mute}, 32'd0);

      // R3: wrong address and read request
      tx[0] = 8'h00; tx[1] = 8'h01;
      xfer(7'h40, 1'b0, 2);
      chk("R3 mismatch nack", {30'd0, ack_r[0], ack_r[2]}, 32'd0);
      chk_regs("R3 mismatch ignored");
      xfer(ADDR, 1'b1, 2);
      chk("R3 read nack", {30'd0, ack_r[0], ack_r[1]}, 32'd0);
      chk_regs("R3 read ignored");

      // R7 R2: repeated start in the middle of a data byte
      i2c_start();
      send_byte({ADDR, 1'b0}, ak);
      send_byte(8'h00, ak);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      i2c_start();
      send_byte({ADDR, 1'b0}, ak);
      chk("R2 restart acked", {31'd0, ak}, 32'd1);
      send_byte(8'h01, ak);
      send_byte(8'h07, ak);
      i2c_stop(); wait_cyc(10);
      model_write(8'h01, 8'h07);
      chk_regs("R7 R2 partial byte then restart");

      // R7: stop in the middle of a data byte
      i2c_start();
      send_byte({ADDR, 1'b0}, ak);
      send_byte(8'h03, ak);
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      i2c_stop(); wait_cyc(10);
      chk_regs("R7 partial byte then stop");
      chk("R2 no pull after stop", {31'd0, sda_pull}, 32'd0);

      // R9: glitches on both lines
      glitch_en = 1'b1;
      tx[0] = 8'h02; tx[1] = 8'hFD;
      xfer(ADDR, 1'b0, 2);
      glitch_en = 1'b0;
      model_write(8'h02, 8'hFD);
      chk_regs("R9 glitches filtered");
      chk("R9 acks with glitches", {30'd0, ack_r[0], ack_r[2]}, 32'd3);

      // R11: mute again by switch write
      tx[0] = 8'h08; tx[1] = 8'hE0;
      xfer(ADDR, 1'b0, 2);
      model_write(8'h08, 8'hE0);
      chk("R11 muted again", {31'd0, mute}, 32'd1);

      // R10: 100 kHz timing
      q = 250;
      tx[0] = 8'h00; tx[1] = 8'h1B;
      xfer(ADDR, 1'b0, 2);
      q = 20;
      model_write(8'h00, 8'h1B);
      chk_regs("R10 slow bus");
      chk("R10 R8 slow acks", {30'd0, ack_r[0], ack_r[2]}, 32'd3);

      // R1 R11: reset re-mutes and clears fields
      tx[0] = 8'h08; tx[1] = 8'h0F;
      xfer(ADDR, 1'b0, 2);
      chk("R11 clear before reset", {31'd0, mute}, 32'd0);
      rst_n = 1'b0; wait_cyc(3);
      model_reset();
      chk_regs("R1 reset during use");
      rst_n = 1'b1; wait_cyc(5);
      chk("R1 R11 muted after reset", {31'd0, mute}, 32'd1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 180000) begin
         fails = fails + 1;
         tests = tests + 1;
         $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule